// File: doc/BRIEF.md
# Cascadable serial configuration memory

This block is a read-only store, one bit wide, that streams a fixed bitstream to a programmable-logic device one bit per clock. An address counter selects the bit shown on the data line. Each rising clock edge moves the counter to the next bit, but only while the device is selected and has not yet run out of bits. The stored pattern and the depth are build-time parameters.

A single control input serves two purposes. At its active level it resets the counter and stops the device from driving the line. A parameter sets whether that active level is high or low.

Several devices can be chained. All of them share one clock and one data line. Each device's cascade output, which is active low, feeds the select input of the next device. When a device sends its last bit, it releases the line and asserts its cascade output. The next device then starts streaming from its own first bit, so the chain behaves as one longer memory.

Top module: `sercfg_mem`

## Requirements
- R1: After reset is released with `sel_n` low, `data_out` shows `CONTENT[0]`. After k enabled rising edges it shows `CONTENT[k]`, for k below `DEPTH`. Bit i of `CONTENT` is the i-th bit sent.
- R2: With `RST_HIGH`=1 the reset level of `oe_rst` is 1. With `RST_HIGH`=0 the reset level is 0. The non-reset level never clears the device.
- R3: While `oe_rst` is at its reset level, `data_oe` is 0 in the same cycle. At the next rising edge the counter returns to bit 0 and `cas_en_n` goes back to 1.
- R4: While `sel_n` is 1, `data_oe` is 0 and the counter holds. When `sel_n` returns to 0, streaming resumes at the same bit.
- R5: The edge that follows the presentation of bit `DEPTH`-1 drives `cas_en_n` to 0 and `data_oe` to 0. Both stay there, whatever further clocks arrive, until a reset.
- R6: In a chain of two devices, the shared line carries the first device's content followed by the second device's content, and at most one device has `data_oe` at 1 at any time.
- R7: Whenever `data_oe` is 0, `data_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared configuration clock; the counter moves on the rising edge |
| sel_n | input | 1 | Device select, active low; in a chain it comes from the previous device's `cas_en_n` |
| oe_rst | input | 1 | Combined output enable and reset; the parameter `RST_HIGH` sets the reset level |
| data_out | output | 1 | The current bit of the stream; 0 when not driving |
| data_oe | output | 1 | High when this device drives the shared line; stands in for the high-impedance control |
| cas_en_n | output | 1 | Cascade enable, active low; asserted once the last bit has been sent |

## Verification
Output enable reacts in the same cycle to `sel_n` and `oe_rst`, because it is combinational. The bench therefore checks it one time unit after it drives an input on a falling edge, before any rising edge. The counter, and so the data bit and the cascade output, change one rising edge after the stimulus. Those are sampled two time units after that edge. The chain is swept bit by bit across both devices, and the expected bit is computed from the two content parameters. A single device built with the opposite reset polarity covers the other setting.

// File: rtl/sercfg_mem.sv
module sercfg_mem #(
  parameter int DEPTH = 16,
  parameter bit RST_HIGH = 1'b1,
  parameter logic [DEPTH-1:0] CONTENT = '0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic sel_n,
  input  logic oe_rst,
  output logic data_out,
  output logic data_oe,
  output logic cas_en_n
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr;
  logic          done;
  logic          rst_act;

  assign rst_act = (oe_rst == RST_HIGH);

  always_ff @(posedge clk) begin
    if (rst_act) begin
      addr <= '0;
      done <= 1'b0;
    end else if (!sel_n && !done) begin
      if (addr == LAST) done <= 1'b1;
      else              addr <= addr + AW'(1);
    end
  end

  assign data_oe  = !sel_n && !rst_act && !done;
  assign data_out = data_oe & CONTENT[addr];
  assign cas_en_n = !done;

endmodule

module sercfg_mem_chk #(
  parameter int DEPTH = 16,
  parameter bit RST_HIGH = 1'b1,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          sel_n,
  input logic          oe_rst,
  input logic          data_out,
  input logic          data_oe,
  input logic          cas_en_n,
  input logic [AW-1:0] addr,
  input logic          done
);

  logic rst_act;
  assign rst_act = (oe_rst == RST_HIGH);

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst_act)
    (!sel_n && !done && addr != AW'(DEPTH - 1)) |=> (addr == $past(addr) + AW'(1))); // R1
  AST_RESET_BLOCKS_DRIVE: assert property (@(posedge clk)
    rst_act |-> !data_oe); // R3
  AST_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (rst_act)
    sel_n |=> $stable(addr)); // R4
  AST_TERMINAL_CASCADE: assert property (@(posedge clk) disable iff (rst_act)
    (!sel_n && !done && addr == AW'(DEPTH - 1)) |=> !cas_en_n); // R5
  AST_CASCADE_STICKY: assert property (@(posedge clk) disable iff (rst_act)
    !cas_en_n |=> !cas_en_n); // R5
  AST_RELEASE_AFTER_TC: assert property (@(posedge clk) disable iff (rst_act)
    !cas_en_n |-> !data_oe); // R6
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst_act)
    !data_oe |-> !data_out); // R7

endmodule

bind sercfg_mem sercfg_mem_chk #(.DEPTH(DEPTH), .RST_HIGH(RST_HIGH), .AW(AW)) chk_i (
  .clk(clk), .sel_n(sel_n), .oe_rst(oe_rst), .data_out(data_out),
  .data_oe(data_oe), .cas_en_n(cas_en_n), .addr(addr), .done(done)
);

// File: tb/sercfg_mem_tb.sv
module sercfg_mem_tb_top;

  localparam int D = 8;
  localparam logic [D-1:0] C0 = 8'b1011_0100;
  localparam logic [D-1:0] C1 = 8'b0001_1101;
  localparam logic [D-1:0] CB = 8'b0110_1001;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_a = 1'b1, sel_a = 1'b0, rst_b = 1'b0;
  logic d0, oe0, cas0, d1, oe1, cas1, db, oeb, casb;
  int errors = 0, checks = 0;

  sercfg_mem #(.DEPTH(D), .RST_HIGH(1'b1), .CONTENT(C0)) dut_i (
    .clk(clk), .sel_n(sel_a), .oe_rst(rst_a), .data_out(d0), .data_oe(oe0), .cas_en_n(cas0));
  sercfg_mem #(.DEPTH(D), .RST_HIGH(1'b1), .CONTENT(C1)) dut2_i (
    .clk(clk), .sel_n(cas0), .oe_rst(rst_a), .data_out(d1), .data_oe(oe1), .cas_en_n(cas1));
  sercfg_mem #(.DEPTH(D), .RST_HIGH(1'b0), .CONTENT(CB)) dutb_i (
    .clk(clk), .sel_n(1'b0), .oe_rst(rst_b), .data_out(db), .data_oe(oeb), .cas_en_n(casb));

  logic bus;
  assign bus = oe0 ? d0 : (oe1 ? d1 : 1'b0);

  function automatic logic exp_a(int k);
    return (k < D) ? C0[k] : C1[k-D];
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) tick();
    check("R3 reset oe0", oe0, 0);
    check("R3 reset oe1", oe1, 0);
    check("R3 reset cas0", cas0, 1);
    check("R3 reset cas1", cas1, 1);
    check("R2 low level resets B", oeb, 0);

    @(negedge clk) rst_a = 1'b0; #1;
    check("R1 first bit", bus, exp_a(0));
    check("R6 only first drives", oe0 + oe1, 1);
    for (int k = 1; k < 2*D; k++) begin
      tick();
      check($sformatf("R1/R6 chain bit %0d", k), bus, exp_a(k));
      check($sformatf("R6 single driver %0d", k), oe0 + oe1, 1);
      if (k == D) check("R5 handoff cas0", cas0, 0);
    end
    tick();
    check("R5 end oe0", oe0, 0);
    check("R5 end oe1", oe1, 0);
    check("R5 end cas1", cas1, 0);
    check("R7 idle data", d0 | d1, 0);
    repeat (3) tick();
    check("R5 sticky cas0", cas0, 0);
    check("R5 sticky cas1", cas1, 0);
    check("R5 sticky oe", oe0 | oe1, 0);

    @(negedge clk) rst_a = 1'b1;
    tick();
    @(negedge clk) rst_a = 1'b0;
    repeat (3) tick();
    check("R1 bit 3", bus, exp_a(3));
    @(negedge clk) sel_a = 1'b1; #1;
    check("R4 deselect oe0", oe0, 0);
    check("R7 deselect data", d0, 0);
    repeat (4) tick();
    check("R4 still off", oe0, 0);
    @(negedge clk) sel_a = 1'b0; #1;
    check("R4 resume same bit", bus, exp_a(3));
    tick();
    check("R4 resume next bit", bus, exp_a(4));

    @(negedge clk) rst_a = 1'b1; #1;
    check("R3 immediate release", oe0, 0);
    tick();
    @(negedge clk) rst_a = 1'b0; #1;
    check("R3 back to bit 0", bus, exp_a(0));
    check("R3 cas cleared", cas0, 1);

    @(negedge clk) rst_b = 1'b1; #1;
    check("R2 high level runs B", oeb, 1);
    check("R2 B bit 0", db, CB[0]);
    for (int k = 1; k < D; k++) begin
      tick();
      check($sformatf("R1 B bit %0d", k), db, CB[k]);
    end
    tick();
    check("R5 B cascade", casb, 0);
    check("R5 B released", oeb, 0);
    @(negedge clk) rst_b = 1'b0; #1;
    check("R2 B reset off", oeb, 0);
    tick();
    check("R2 B cas cleared", casb, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule